// File: doc/BRIEF.md
# Three-Master Partial Crossbar with Strict Priority

This block connects three bus masters (a DMA engine, an external host port and a CPU) to two targets: an internal memory port and a peripheral port. Each master drives a single-beat request with address, write enable and write data, and receives read data, a ready strobe and an error flag. Each target receives a request with the forwarded address, write enable and write data, and answers with its own ready and read data. One address bit picks the target for every request.

The masters reach different targets in the same cycle without disturbing one another. When several masters want the same idle target, a strict ranking decides: DMA first, host second, CPU last. Once a target has been handed to a master, it stays with that master until the target answers ready, so a transfer that has begun cannot be preempted. One route is not wired, host to peripheral. A request on it finishes in the same cycle with ready and error both set, and no target sees it.

Top module: `prio_xbar`

## Requirements
- R1: While reset is held, and after reset with no requests, no target request and no master ready or error is asserted.
- R2: Address bit SEL_BIT of a master's address selects the target (0 memory, 1 peripheral). The target granted to a master receives that master's address, write enable and write data unchanged.
- R3: Masters that address different targets are both served in the same cycle. Each receives ready in the cycle its own target asserts ready.
- R4: When an idle target is requested by several masters on legal routes, it is given to the master with the lowest index: DMA (index 0) over host (index 1) over CPU (index 2).
- R5: A host (index 1) request to the peripheral target raises that master's ready and error in the same cycle and raises no target request. A legal request never raises error.
- R6: A target that has asserted request without ready keeps the same owner in the next cycle, even if a higher-priority master has begun requesting it.
- R7: A master receives ready only in a cycle in which its own target grants it and asserts ready. In that cycle its read data equals the read data of that target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mReq | input | 3 | Per-master request (0 DMA, 1 host, 2 CPU) |
| mAddr | input | 3 x ADDR_W | Per-master address |
| mWe | input | 3 | Per-master write enable |
| mWdata | input | 3 x DATA_W | Per-master write data |
| mRdata | output | 3 x DATA_W | Per-master read data, valid with ready |
| mReady | output | 3 | Per-master transfer completion |
| mErr | output | 3 | Per-master error for an unwired route |
| tgtReq | output | 2 | Per-target request (0 memory, 1 peripheral) |
| tgtAddr | output | 2 x ADDR_W | Address forwarded to each target |
| tgtWe | output | 2 | Write enable forwarded to each target |
| tgtWdata | output | 2 x DATA_W | Write data forwarded to each target |
| tgtRdata | input | 2 x DATA_W | Read data from each target |
| tgtReady | input | 2 | Per-target completion of the forwarded request |

## Verification
The assertions assume that a master whose request has not yet received ready keeps the request high and the address unchanged into the next cycle. They also assume that a target raises ready only while its request is high. The stimulus keeps within both. Every master holds its request and address until it sees ready and drops the request only after that edge. The bench's target models raise ready from a per-target wait counter gated by the target's own request. The sweep covers all 27 idle/memory/peripheral combinations across the three masters, each with several target wait lengths, plus late-arriving higher-priority requests against a target that is already owned.

// File: rtl/prio_xbar_pkg.sv
package prio_xbar_pkg;
  localparam int NUM_M = 3;
  localparam int NUM_T = 2;
  localparam int IDX_W = $clog2(NUM_M);

  typedef struct packed {
    logic [NUM_T-1:0]            tgtActive;
    logic [NUM_T-1:0][IDX_W-1:0] tgtOwner;
    logic [NUM_M-1:0]            mstReady;
    logic [NUM_M-1:0]            mstErr;
  } xbarStrobe_t;
endpackage

// File: rtl/prio_xbar_ctrl.sv
module prio_xbar_ctrl
  import prio_xbar_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_BIT = 15,
  parameter logic [NUM_M*NUM_T-1:0] ROUTE_MASK = 6'b110111
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_M-1:0]                  mReq,
  input  logic [NUM_M-1:0][ADDR_W-1:0]      mAddr,
  input  logic [NUM_T-1:0]                  tgtReady,
  output xbarStrobe_t                       strb
);
  logic [NUM_M-1:0]            mTgt;
  logic [NUM_M-1:0]            legal;
  logic [NUM_T-1:0][NUM_M-1:0] cand;
  logic [NUM_T-1:0][IDX_W-1:0] winIdx;
  logic [NUM_T-1:0]            locked;
  logic [NUM_T-1:0][IDX_W-1:0] lockOwner;

  always_comb begin
    for (int m = 0; m < NUM_M; m++) begin
      mTgt[m]  = mAddr[m][SEL_BIT];
      legal[m] = ROUTE_MASK[m*NUM_T + int'(mTgt[m])];
    end
  end

  genvar t;
  generate
    for (t = 0; t < NUM_T; t++) begin : g_tgt
      always_comb begin
        for (int m = 0; m < NUM_M; m++)
          cand[t][m] = mReq[m] && legal[m] && (int'(mTgt[m]) == t);
        winIdx[t] = '0;
        for (int m = NUM_M - 1; m >= 0; m--)
          if (cand[t][m]) winIdx[t] = IDX_W'(m);
        strb.tgtActive[t] = locked[t] || (|cand[t]);
        strb.tgtOwner[t]  = locked[t] ? lockOwner[t] : winIdx[t];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          locked[t]    <= 1'b0;
          lockOwner[t] <= '0;
        end else begin
          locked[t]    <= strb.tgtActive[t] && !tgtReady[t];
          lockOwner[t] <= strb.tgtOwner[t];
        end
      end

      // R6: an owned target that has not answered keeps its owner
      assert_hold_owner_R6: assert property (@(posedge clk) disable iff (!rstN)
        (strb.tgtActive[t] && !tgtReady[t]) |=>
          (strb.tgtActive[t] && strb.tgtOwner[t] == $past(strb.tgtOwner[t])));

      // R4: an idle target goes to the DMA master when it asks legally
      assert_dma_first_R4: assert property (@(posedge clk) disable iff (!rstN)
        (!locked[t] && mReq[0] && int'(mAddr[0][SEL_BIT]) == t && ROUTE_MASK[t]) |->
          (strb.tgtActive[t] && strb.tgtOwner[t] == IDX_W'(0)));

      // R4: host beats CPU when DMA is absent from an idle target
      assert_host_over_cpu_R4: assert property (@(posedge clk) disable iff (!rstN)
        (!locked[t] && !(mReq[0] && int'(mAddr[0][SEL_BIT]) == t && ROUTE_MASK[t]) &&
         mReq[1] && int'(mAddr[1][SEL_BIT]) == t && ROUTE_MASK[NUM_T + t]) |->
          (strb.tgtOwner[t] == IDX_W'(1)));

      // R5: no target is ever owned through an unwired route
      assert_no_illegal_owner_R5: assert property (@(posedge clk) disable iff (!rstN)
        strb.tgtActive[t] |-> ROUTE_MASK[int'(strb.tgtOwner[t])*NUM_T + t]);
    end
  endgenerate

  always_comb begin
    for (int m = 0; m < NUM_M; m++) begin
      strb.mstErr[m]   = mReq[m] && !legal[m];
      strb.mstReady[m] = strb.mstErr[m];
      for (int k = 0; k < NUM_T; k++)
        if (strb.tgtActive[k] && strb.tgtOwner[k] == IDX_W'(m) && tgtReady[k])
          strb.mstReady[m] = 1'b1;
    end
  end

  generate
    for (genvar m = 0; m < NUM_M; m++) begin : g_mst
      // R5: an error always completes the request in the same cycle
      assert_err_is_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
        strb.mstErr[m] |-> strb.mstReady[m]);

      // R6: input assumption, a waiting master holds request and address
      assert_master_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
        (mReq[m] && !strb.mstReady[m]) |=> (mReq[m] && $stable(mAddr[m])));
    end
  endgenerate
endmodule

// File: rtl/prio_xbar_dpath.sv
module prio_xbar_dpath
  import prio_xbar_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEL_BIT = 15
) (
  input  xbarStrobe_t                  strb,
  input  logic [NUM_M-1:0][ADDR_W-1:0] mAddr,
  input  logic [NUM_M-1:0]             mWe,
  input  logic [NUM_M-1:0][DATA_W-1:0] mWdata,
  output logic [NUM_M-1:0][DATA_W-1:0] mRdata,
  output logic [NUM_T-1:0]             tgtReq,
  output logic [NUM_T-1:0][ADDR_W-1:0] tgtAddr,
  output logic [NUM_T-1:0]             tgtWe,
  output logic [NUM_T-1:0][DATA_W-1:0] tgtWdata,
  input  logic [NUM_T-1:0][DATA_W-1:0] tgtRdata
);
  assign tgtReq = strb.tgtActive;

  always_comb begin
    for (int t = 0; t < NUM_T; t++) begin
      tgtAddr[t]  = '0;
      tgtWe[t]    = 1'b0;
      tgtWdata[t] = '0;
      for (int m = 0; m < NUM_M; m++) begin
        if (strb.tgtActive[t] && strb.tgtOwner[t] == IDX_W'(m)) begin
          tgtAddr[t]  = mAddr[m];
          tgtWe[t]    = mWe[m];
          tgtWdata[t] = mWdata[m];
        end
      end
    end
  end

  always_comb begin
    for (int m = 0; m < NUM_M; m++) begin
      mRdata[m] = '0;
      if (strb.mstReady[m] && !strb.mstErr[m])
        mRdata[m] = tgtRdata[int'(mAddr[m][SEL_BIT])];
    end
  end
endmodule

// File: rtl/prio_xbar.sv
module prio_xbar
  import prio_xbar_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEL_BIT = ADDR_W - 1,
  parameter logic [NUM_M*NUM_T-1:0] ROUTE_MASK = 6'b110111
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_M-1:0]                 mReq,
  input  logic [NUM_M-1:0][ADDR_W-1:0]     mAddr,
  input  logic [NUM_M-1:0]                 mWe,
  input  logic [NUM_M-1:0][DATA_W-1:0]     mWdata,
  output logic [NUM_M-1:0][DATA_W-1:0]     mRdata,
  output logic [NUM_M-1:0]                 mReady,
  output logic [NUM_M-1:0]                 mErr,
  output logic [NUM_T-1:0]                 tgtReq,
  output logic [NUM_T-1:0][ADDR_W-1:0]     tgtAddr,
  output logic [NUM_T-1:0]                 tgtWe,
  output logic [NUM_T-1:0][DATA_W-1:0]     tgtWdata,
  input  logic [NUM_T-1:0][DATA_W-1:0]     tgtRdata,
  input  logic [NUM_T-1:0]                 tgtReady
);
  xbarStrobe_t strb;

  prio_xbar_ctrl #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .ROUTE_MASK(ROUTE_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mAddr(mAddr),
    .tgtReady(tgtReady), .strb(strb)
  );

  prio_xbar_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_BIT(SEL_BIT)) u_dpath (
    .strb(strb), .mAddr(mAddr), .mWe(mWe), .mWdata(mWdata), .mRdata(mRdata),
    .tgtReq(tgtReq), .tgtAddr(tgtAddr), .tgtWe(tgtWe), .tgtWdata(tgtWdata),
    .tgtRdata(tgtRdata)
  );

  assign mReady = strb.mstReady;
  assign mErr   = strb.mstErr;
endmodule

// File: tb/prio_xbar_tb.sv
module prio_xbar_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [31:0] MEM_K = 32'hA5A5_0000;
  localparam logic [31:0] PER_K = 32'h5A5A_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0]          mReq = '0;
  logic [2:0][AW-1:0]  mAddr = '0;
  logic [2:0]          mWe = '0;
  logic [2:0][DW-1:0]  mWdata = '0;
  logic [2:0][DW-1:0]  mRdata;
  logic [2:0]          mReady, mErr;
  logic [1:0]          tgtReq;
  logic [1:0][AW-1:0]  tgtAddr;
  logic [1:0]          tgtWe;
  logic [1:0][DW-1:0]  tgtWdata;
  logic [1:0][DW-1:0]  tgtRdata;
  logic [1:0]          tgtReady;

  int cnt [2];
  int curDelay = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  prio_xbar u_dut (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mAddr(mAddr), .mWe(mWe), .mWdata(mWdata),
    .mRdata(mRdata), .mReady(mReady), .mErr(mErr), .tgtReq(tgtReq), .tgtAddr(tgtAddr),
    .tgtWe(tgtWe), .tgtWdata(tgtWdata), .tgtRdata(tgtRdata), .tgtReady(tgtReady)
  );

  // target models: answer after curDelay waiting cycles, data derived from address
  always_comb begin
    for (int t = 0; t < 2; t++)
      tgtReady[t] = tgtReq[t] && (cnt[t] >= curDelay);
    tgtRdata[0] = {16'h0, tgtAddr[0]} ^ MEM_K;
    tgtRdata[1] = {16'h0, tgtAddr[1]} ^ PER_K;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit legalRoute(input int m, input int t);
    return !(m == 1 && t == 1);
  endfunction

  // one scenario: tgtSel per master (0 idle, 1 memory, 2 peripheral), late start
  task automatic runCase(input int sel [3], input int delay, input int lateM, input int lateCyc);
    bit pend [3];
    int tgtOf [3];
    bit refLocked [2];
    int refOwner [2];
    int cyc = 0;
    bit busy;
    curDelay = delay;
    cnt[0] = 0; cnt[1] = 0;
    refLocked[0] = 0; refLocked[1] = 0;
    refOwner[0] = 0; refOwner[1] = 0;
    for (int m = 0; m < 3; m++) begin
      tgtOf[m] = sel[m] - 1;
      pend[m] = (sel[m] != 0) && (m != lateM);
      mAddr[m] = {(sel[m] == 2), 7'(m + 1), 4'(delay), 4'(sel[0] + 3*sel[1] + 9*sel[2])};
      mWe[m] = (m != 1);
      mWdata[m] = 32'hC000_0000 | (32'(m) << 16) | 32'(mAddr[m]);
      mReq[m] = pend[m];
    end
    busy = 1;
    while (busy && cyc < 40) begin
      bit done [3];
      bit expAct [2];
      int expOwn [2];
      bit rdyNow [2];
      @(negedge clk);
      for (int t = 0; t < 2; t++) begin
        expAct[t] = 0; expOwn[t] = 0;
        if (refLocked[t]) begin expAct[t] = 1; expOwn[t] = refOwner[t]; end
        else
          for (int m = 2; m >= 0; m--)
            if (pend[m] && tgtOf[m] == t && legalRoute(m, t)) begin expAct[t] = 1; expOwn[t] = m; end
        rdyNow[t] = expAct[t] && (cnt[t] >= delay);
        chk(tgtReq[t] == expAct[t], refLocked[t] ? "R6 owner held" : "R4 target request",
            32'(tgtReq[t]), 32'(expAct[t]));
        if (expAct[t]) begin
          chk(tgtAddr[t] == mAddr[expOwn[t]], refLocked[t] ? "R6 owner address" : "R4 winner address",
              32'(tgtAddr[t]), 32'(mAddr[expOwn[t]]));
          chk(tgtWdata[t] == mWdata[expOwn[t]] && tgtWe[t] == mWe[expOwn[t]], "R2 write forwarding",
              tgtWdata[t], mWdata[expOwn[t]]);
        end
      end
      for (int m = 0; m < 3; m++) begin
        bit eErr, eRdy;
        eErr = pend[m] && !legalRoute(m, tgtOf[m]);
        eRdy = eErr || (pend[m] && expAct[tgtOf[m]] && expOwn[tgtOf[m]] == m && rdyNow[tgtOf[m]]);
        chk(mErr[m] == eErr, "R5 error flag", 32'(mErr[m]), 32'(eErr));
        chk(mReady[m] == eRdy, "R3 master ready", 32'(mReady[m]), 32'(eRdy));
        if (eRdy && !eErr)
          chk(mRdata[m] == ({16'h0, mAddr[m]} ^ (tgtOf[m] == 1 ? PER_K : MEM_K)), "R7 read data",
              mRdata[m], {16'h0, mAddr[m]} ^ (tgtOf[m] == 1 ? PER_K : MEM_K));
        done[m] = eRdy;
      end
      @(posedge clk);
      #1;
      for (int t = 0; t < 2; t++) begin
        refLocked[t] = expAct[t] && !rdyNow[t];
        refOwner[t] = expOwn[t];
        cnt[t] = (expAct[t] && !rdyNow[t]) ? cnt[t] + 1 : 0;
      end
      cyc++;
      busy = 0;
      for (int m = 0; m < 3; m++) begin
        if (done[m]) pend[m] = 0;
        if (m == lateM && cyc == lateCyc && sel[m] != 0) pend[m] = 1;
        mReq[m] = pend[m];
        if (pend[m] || (m == lateM && cyc < lateCyc && sel[m] != 0)) busy = 1;
      end
    end
    chk(!busy, "R3 scenario completion", 32'(busy), 32'd0);
    mReq = '0;
    @(negedge clk);
    chk(tgtReq == 2'b00 && mReady == 3'b000, "R1 idle after scenario", 32'({tgtReq, mReady}), 32'd0);
  endtask

  initial begin
    int s [3];
    int dl [3] = '{0, 1, 3};
    cnt[0] = 0; cnt[1] = 0;
    repeat (3) @(negedge clk);
    chk(tgtReq == 2'b00 && mReady == 3'b000 && mErr == 3'b000, "R1 reset state",
        32'({tgtReq, mReady, mErr}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(tgtReq == 2'b00 && mReady == 3'b000 && mErr == 3'b000, "R1 idle after reset",
        32'({tgtReq, mReady, mErr}), 32'd0);
    // exhaustive sweep of all request combinations against several wait lengths
    for (int d = 0; d < 3; d++)
      for (int c = 0; c < 27; c++) begin
        s[0] = c % 3; s[1] = (c / 3) % 3; s[2] = c / 9;
        runCase(s, dl[d], -1, 0);
      end
    // R6: DMA arrives while CPU already owns memory
    s[0] = 1; s[1] = 0; s[2] = 1;
    runCase(s, 3, 0, 1);
    // R6: host arrives while CPU owns memory, DMA on peripheral in parallel
    s[0] = 2; s[1] = 1; s[2] = 1;
    runCase(s, 2, 1, 1);
    // R6: DMA late onto peripheral owned by CPU
    s[0] = 2; s[1] = 2; s[2] = 2;
    runCase(s, 3, 0, 2);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule